// File: doc/BRIEF.md
# Programmable-Flag Dual-Clock FIFO

This block is a first-in first-out buffer for 9-bit words. Its depth is a power-of-two parameter between 256 and 8192. The write side and the read side each have their own clock. The two clocks may be one shared net or may be fully unrelated. A transfer on either side happens only when both of that side's two enable inputs are high. This lets two independent agents, such as an arbiter and a datapath stage, gate the same port without an external AND gate.

The block drives four flags:

- **Empty** is computed in the read domain.
- **Full** is computed in the write domain.
- **Almost-empty** and **almost-full** compare the fill level against two thresholds held in offset registers. Both thresholds are 7 after reset.

The thresholds are programmed through the data port. While the load select is high, a qualified write goes to an offset register instead of the storage array. The read data is held in an output register. That register is driven onto the pins only while the output enable is high.

Both pointers cross between the clock domains as Gray code through two-flop synchronizers. A flag that depends on the far side's pointer therefore clears two local clock edges after the far side moves.

The offset loader is a two-state machine:

- **`LOAD_AE`** is the state after reset. In this state, a load write sets the almost-empty offset and moves the machine to `LOAD_AF`.
- **`LOAD_AF`**: a load write sets the almost-full offset and returns the machine to `LOAD_AE`.
- From either state, a qualified write with the load select low returns the machine to `LOAD_AE`.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset, empty and almost_empty are 1, full and almost_full are 0, rd_data is 0 with out_en high, and both offsets are 7.
- R2: A word is stored on a rising wr_clk edge only when wr_en_a and wr_en_b are both 1 and load_sel is 0. One enable alone has no effect.
- R3: A word is read on a rising rd_clk edge only when rd_en_a and rd_en_b are both 1 and empty is 0. rd_data shows that word, in write order, from that edge on.
- R4: A write while full is ignored and the stored contents are unchanged.
- R5: A read while empty is ignored and rd_data holds its last value.
- R6: Full rises on the write edge that makes the level equal to the depth, and clears two wr_clk edges after a read. Empty clears two rd_clk edges after a write and rises on the read edge that takes the last visible word.
- R7: almost_empty is 1 exactly when (words visible to the read side) <= the almost-empty offset.
- R8: almost_full is 1 exactly when (words visible to the write side) >= depth minus the almost-full offset.
- R9: A write with load_sel=1 and both write enables loads the low log2(depth) bits of wr_data into an offset register. Load writes alternate, almost-empty offset first and then almost-full offset. A plain qualified write restarts the order at the almost-empty offset. Load writes store nothing in the buffer.
- R10: With out_en=0, rd_data is high impedance. The output register is unaffected, and the held word reappears when out_en returns to 1.
- R11: With unrelated clocks, every word is delivered once, in order, and each Gray pointer changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en_a | input | 1 | First write qualifier |
| wr_en_b | input | 1 | Second write qualifier |
| load_sel | input | 1 | Route qualified writes to the offset registers |
| wr_data | input | WIDTH (9) | Write word or offset value |
| rd_en_a | input | 1 | First read qualifier |
| rd_en_b | input | 1 | Second read qualifier |
| out_en | input | 1 | Drive rd_data when 1, high impedance when 0 |
| rd_data | output | WIDTH (9) | Registered read word |
| empty | output | 1 | No word visible to the read side |
| full | output | 1 | Depth words visible to the write side |
| almost_empty | output | 1 | Read-side level at or below the almost-empty offset |
| almost_full | output | 1 | Write-side level at or above depth minus the almost-full offset |

## Verification
The assertions take several things for granted about the inputs:

- The offset registers change only while the read side is quiet. The almost-empty offset is used in the read domain without its own synchronizer.
- The reset is applied to both domains together.
- The enables are stable around each clock edge.

The stimulus follows these assumptions as described below:

- It programs the offsets only when the buffer is idle.
- It changes every input on a falling edge of the write clock.
- In the unrelated-clock phase, it drives the write side only after the read side has been reset and drives the read side only from the read clock.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    // Offset loader states: which threshold the next load write sets
    typedef enum logic {
        LOAD_AE = 1'b0,
        LOAD_AF = 1'b1
    } load_state_e;

endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int WIDTH  = 9,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rq
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Output register: changes only on a real read
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)  rq <= '0;
        else if (re) rq <= store[raddr];
    end
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
    import fifo_pkg::*;
#(
    parameter int WIDTH      = 9,
    parameter int DEPTH      = 256,
    parameter int DEF_OFFSET = 7,
    parameter int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic              load_sel,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              mem_we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full,
    output logic              almost_full,
    output logic [ADDR_W-1:0] ae_off
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wbin, wbin_nx, rbin_s, level;
    logic [ADDR_W-1:0] af_off, off_in;
    logic              wr_req, load_fire, push;
    load_state_e       ld_state, ld_next;

    assign wr_req    = wr_en_a & wr_en_b;
    assign load_fire = wr_req & load_sel;
    assign push      = wr_req & ~load_sel & ~full;
    assign wbin_nx   = wbin + PW'(push);
    assign mem_we    = push;
    assign waddr     = wbin[ADDR_W-1:0];

    // Offset value taken from the data port
    generate
        if (ADDR_W <= WIDTH) begin : g_off_slice
            assign off_in = wr_data[ADDR_W-1:0];
        end else begin : g_off_ext
            assign off_in = {{(ADDR_W-WIDTH){1'b0}}, wr_data};
        end
    endgenerate

    // Read pointer seen from this domain, back to binary
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_sync >> i);
    end

    assign level       = wbin - rbin_s;
    assign full        = (level == PW'(DEPTH));
    assign almost_full = (level >= (PW'(DEPTH) - {1'b0, af_off}));

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Loader state register
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) ld_state <= LOAD_AE;
        else        ld_state <= ld_next;
    end

    // Loader transitions
    always_comb begin
        ld_next = ld_state;
        unique case (ld_state)
            LOAD_AE: begin
                if (load_fire)   ld_next = LOAD_AF;
                else if (wr_req) ld_next = LOAD_AE;
            end
            LOAD_AF: begin
                if (load_fire)   ld_next = LOAD_AE;
                else if (wr_req) ld_next = LOAD_AE;
            end
            default: ld_next = LOAD_AE;
        endcase
    end

    // Loader outputs: the offset registers
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_off <= ADDR_W'(DEF_OFFSET);
            af_off <= ADDR_W'(DEF_OFFSET);
        end else if (load_fire) begin
            unique case (ld_state)
                LOAD_AE: ae_off <= off_in;
                LOAD_AF: af_off <= off_in;
                default: ae_off <= off_in;
            endcase
        end
    end

    // R4: the write-side level never exceeds the depth
    p_no_overflow_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        level <= PW'(DEPTH));

    // R8: a full buffer is always also almost full
    p_full_af_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);

    // R9: a load in the first state moves on to the second threshold
    p_loader_alt_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (load_fire && ld_state == LOAD_AE) |=> (ld_state == LOAD_AF));

    // R11: the crossing pointer moves by at most one bit
    p_wgray_step_r11: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [ADDR_W-1:0] ae_off,
    output logic              mem_re,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rbin, rbin_nx, wbin_s, level;
    logic          pop;

    assign empty   = (rgray == wgray_sync);
    assign pop     = rd_en_a & rd_en_b & ~empty;
    assign rbin_nx = rbin + PW'(pop);
    assign mem_re  = pop;
    assign raddr   = rbin[ADDR_W-1:0];

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_sync >> i);
    end

    assign level        = wbin_s - rbin;
    assign almost_empty = (level <= {1'b0, ae_off});

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // R1: the first edge after reset sees an empty, almost-empty buffer
    p_reset_empty_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty && almost_empty));

    // R7: the gray-compare empty and the level threshold agree
    p_empty_ae_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);

    // R11: the crossing pointer moves by at most one bit
    p_rgray_step_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
    parameter int WIDTH      = 9,
    parameter int DEPTH      = 256,
    parameter int DEF_OFFSET = 7
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_en_a,
    input  logic             wr_en_b,
    input  logic             load_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en_a,
    input  logic             rd_en_b,
    input  logic             out_en,
    output wire  [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             almost_empty,
    output logic             almost_full
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic [ADDR_W:0]   wgray, rgray, wgray_rs, rgray_ws;
    logic [ADDR_W-1:0] waddr, raddr, ae_off;
    logic              mem_we, mem_re;
    logic [WIDTH-1:0]  rd_q;

    fifo_wr_ctrl #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .DEF_OFFSET(DEF_OFFSET), .ADDR_W(ADDR_W)
    ) i_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
        .load_sel(load_sel), .wr_data(wr_data), .rgray_sync(rgray_ws),
        .mem_we(mem_we), .waddr(waddr), .wgray(wgray), .full(full),
        .almost_full(almost_full), .ae_off(ae_off)
    );

    fifo_rd_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
        .wgray_sync(wgray_rs), .ae_off(ae_off), .mem_re(mem_re), .raddr(raddr),
        .rgray(rgray), .empty(empty), .almost_empty(almost_empty)
    );

    fifo_sync2 #(.W(ADDR_W + 1)) i_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_rs)
    );

    fifo_sync2 #(.W(ADDR_W + 1)) i_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_ws)
    );

    fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_mem (
        .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .re(mem_re), .raddr(raddr), .rq(rd_q)
    );

    assign rd_data = out_en ? rd_q : 'z;

    // R5: a read attempt on an empty buffer leaves the output register alone
    p_hold_on_empty_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_en_a && rd_en_b) |=> $stable(rd_q));
endmodule

// File: tb/test_prog_flag_fifo.sv
module test_prog_flag_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int RCLK_B     = 14;
    localparam int DEPTH      = 256;

    logic clk = 1'b0, clk_b = 1'b0, split = 1'b0;
    logic rst_n, wa, wb, ld, ra, rb, oe;
    logic [8:0] wd;
    wire  [8:0] rd_data;
    wire  rd_clk;
    logic empty, full, almost_empty, almost_full;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(RCLK_B/2)     clk_b = ~clk_b;
    assign rd_clk = split ? clk_b : clk;

    prog_flag_fifo #(.WIDTH(9), .DEPTH(DEPTH), .DEF_OFFSET(7)) i_prog_flag_fifo (
        .wr_clk(clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_a(wa), .wr_en_b(wb),
        .load_sel(ld), .wr_data(wd), .rd_en_a(ra), .rd_en_b(rb), .out_en(oe),
        .rd_data(rd_data), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    int checks = 0, errors = 0;
    bit model_on = 1'b0;
    int wcnt, rcnt, ws1, ws2, rs1, rs2, ae_m, af_m;
    bit ld_second;
    logic [8:0] m_dout;
    logic [8:0] q[$];

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        wcnt = 0; rcnt = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
        ae_m = 7; af_m = 7; ld_second = 1'b0; m_dout = '0; q.delete();
    endtask

    // One shared-clock cycle: model the edge, then compare at the falling edge
    task automatic step();
        bit full_pre, empty_pre, wreq, push, pop;
        @(posedge clk);
        #1;
        if (model_on) begin
            full_pre  = ((wcnt - rs2) == DEPTH);
            empty_pre = (ws2 == rcnt);
            wreq = wa && wb;
            if (wreq && ld) begin
                if (!ld_second) ae_m = int'(wd[7:0]); else af_m = int'(wd[7:0]);
                ld_second = !ld_second;
            end else if (wreq) ld_second = 1'b0;
            push = wreq && !ld && !full_pre;
            pop  = ra && rb && !empty_pre;
            ws2 = ws1; ws1 = wcnt; rs2 = rs1; rs1 = rcnt;
            if (pop) begin m_dout = q.pop_front(); rcnt++; end
            if (push) begin q.push_back(wd); wcnt++; end
        end
        @(negedge clk);
        if (model_on) begin
            chk("R6 empty flag", int'(empty), int'(ws2 == rcnt));
            chk("R6 full flag", int'(full), int'((wcnt - rs2) == DEPTH));
            chk("R7 almost_empty", int'(almost_empty), int'((ws2 - rcnt) <= ae_m));
            chk("R8 almost_full", int'(almost_full), int'((wcnt - rs2) >= DEPTH - af_m));
            if (oe) chk("R3 read data", int'(rd_data), int'(m_dout));
        end
    endtask

    task automatic idle(input int n);
        wa = 0; wb = 0; ra = 0; rb = 0; ld = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_n(input int n, input int base);
        ra = 0; rb = 0; ld = 0;
        for (int i = 0; i < n; i++) begin
            wa = 1; wb = 1; wd = 9'(base + i);
            step();
        end
        wa = 0; wb = 0;
    endtask

    task automatic read_n(input int n);
        wa = 0; wb = 0; ld = 0;
        for (int i = 0; i < n; i++) begin
            ra = 1; rb = 1;
            step();
        end
        ra = 0; rb = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; wa = 0; wb = 0; ld = 0; ra = 0; rb = 0; oe = 1; wd = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        model_on = 1'b0;
        do_reset();
        // R1: state straight after reset
        chk("R1 empty", int'(empty), 1);
        chk("R1 almost_empty", int'(almost_empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 almost_full", int'(almost_full), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        model_on = 1'b1;

        // R2: single enables store nothing
        wd = 9'h055; wa = 1; wb = 0; repeat (4) step();
        wa = 0; wb = 1; repeat (4) step();
        idle(3);
        chk("R2 single enable ignored", int'(empty), 1);

        // R7: default almost-empty threshold of 7
        write_n(7, 1);
        idle(3);
        chk("R7 seven words almost empty", int'(almost_empty), 1);
        write_n(1, 8);
        idle(3);
        chk("R7 eight words not almost empty", int'(almost_empty), 0);
        read_n(8);
        idle(3);

        // R4 / R8: fill past full, extra writes rejected
        ra = 0; rb = 0; ld = 0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            wa = 1; wb = 1; wd = 9'(i);
            step();
            if (wcnt == DEPTH - 8 && i == DEPTH - 9)
                chk("R8 level 248 not almost full", int'(almost_full), 0);
            if (wcnt == DEPTH - 7 && i == DEPTH - 8)
                chk("R8 level 249 almost full", int'(almost_full), 1);
        end
        idle(2);
        chk("R4 full held", int'(full), 1);
        read_n(DEPTH);
        chk("R4 last word is the last accepted one", int'(rd_data), DEPTH - 1);
        // R5: reads on empty hold the output
        read_n(3);
        chk("R5 output held on empty", int'(rd_data), DEPTH - 1);
        chk("R5 still empty", int'(empty), 1);

        // R9: loader order and restart on a plain write
        ld = 1; wa = 1; wb = 1; wd = 9'd5; step();
        ld = 0; wd = 9'd77; step();
        ld = 1; wd = 9'd20; step();
        wd = 9'd30; step();
        idle(3);
        write_n(19, 100);
        idle(3);
        chk("R9 level 20 almost empty at offset 20", int'(almost_empty), 1);
        write_n(1, 200);
        idle(3);
        chk("R9 level 21 not almost empty", int'(almost_empty), 0);
        write_n(204, 300);
        idle(3);
        chk("R9 level 225 not almost full at offset 30", int'(almost_full), 0);
        write_n(1, 7);
        idle(3);
        chk("R9 level 226 almost full", int'(almost_full), 1);
        read_n(230);
        idle(3);

        // R3 / R6: mixed random traffic
        for (int i = 0; i < 1500; i++) begin
            wa = ($urandom % 4) != 0; wb = ($urandom % 4) != 0;
            ra = ($urandom % 3) != 0; rb = ($urandom % 4) != 0;
            ld = 0; wd = 9'($urandom);
            step();
        end
        read_n(300);
        idle(3);

        // R10: output enable
        write_n(1, 9'h1A5);
        idle(3);
        read_n(1);
        idle(1);
        oe = 0; step();
        checks++;
        if (!(rd_data === 9'bz || rd_data === 9'b0)) begin
            errors++;
            $display("FAIL R10 disabled output: actual %h expected z", rd_data);
        end
        oe = 1; step();
        chk("R10 held word returns", int'(rd_data), 9'h1A5);

        // R11: unrelated clocks, order preserved
        model_on = 1'b0;
        split = 1'b1;
        do_reset();
        write_n(40, 100);
        begin
            int k = 0;
            for (int t = 0; t < 400 && k < 40; t++) begin
                @(negedge rd_clk);
                if (!empty) begin
                    ra = 1; rb = 1;
                    @(posedge rd_clk); #1;
                    ra = 0; rb = 0;
                    @(negedge rd_clk);
                    chk("R11 async order", int'(rd_data), 100 + k);
                    k++;
                end
            end
            chk("R11 async word count", k, 40);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule